// File: doc/BRIEF.md
# Half-Rate Comma Slot Aligner

This block sits after a character receiver that yields one character per full-rate cycle, each tagged with a comma-detect flag. It groups the characters into pairs for a half-rate consumer. Slot 0 of a pair is the character that would sit on the rising edge of the slow clock, and slot 1 is the character on the opposite edge. When alignment is armed and a comma would fall into slot 1, the block drops the character it is holding. This shifts the pairing by one character and moves the comma into slot 0. The output timing itself is never re-phased: only the data path slips.

Alignment is armed only when three conditions hold together: half-rate output is selected, the framer mode is not switched off, and framing is enabled. If any of them is absent, the pairing runs freely, and a comma can land in slot 1 after an odd count of earlier characters. In full-rate mode each character passes alone in slot 0.

Both stream edges use valid/ready. An input character is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the output never loses or overwrites a pair. A pair is held on the output, unchanged, until `out_ready` takes it. The three mode pins are plain levels.

Top module: `hrca_aligner`

## Requirements
- R1: After reset, `out_valid` is low and the phase is even. No pair is presented until characters have been accepted: two of them in half-rate mode, one in full-rate mode.
- R2: In half-rate mode without a slip, the first accepted character of a pair appears in slot 0 and the second in slot 1. `out_valid` rises in the cycle after the second character is accepted.
- R3: With alignment armed, a comma accepted in the odd phase discards the held character, emits no pair, and becomes the slot 0 character of the next pair.
- R4: With alignment armed, a comma accepted in the even phase is held normally, with no slip, and appears in slot 0 of the next pair.
- R5: When framing is disabled, or the framer mode is off, commas never change the pairing, and a comma may appear in slot 1.
- R6: In full-rate mode (`half_rate` = 0), each accepted character appears in slot 0 with its comma flag in the next cycle. Slot 1 carries character 0 with comma flag 0, and commas never cause a slip.
- R7: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, the slot outputs and `out_valid` hold steady.
- R8: Any cycle in which `half_rate` is low returns the phase to even and discards a held character. The next half-rate character then starts a new pair in slot 0.
- R9: A pair formed from characters accepted while alignment was armed never has its slot 1 comma flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input character is offered |
| in_ready | output | 1 | Block can take a character this cycle |
| in_char | input | CHAR_W | Received character |
| in_comma | input | 1 | Comma-detect flag for `in_char` |
| frm_en | input | 1 | Framing enable |
| frm_mode_off | input | 1 | Framer mode switched off (disables alignment) |
| half_rate | input | 1 | 1: pair output, 0: single characters in slot 0 |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Consumer takes the pair |
| slot0_char | output | CHAR_W | Rising-edge slot character |
| slot0_comma | output | 1 | Comma flag of slot 0 |
| slot1_char | output | CHAR_W | Opposite-edge slot character |
| slot1_comma | output | 1 | Comma flag of slot 1 |

## Verification
The slip and the drain of the output register can fall in the same cycle. A comma accepted in the odd phase discards the held character, and `out_ready` may at that moment be releasing the previous pair, so the output must go empty with no new pair loaded. This overlap is provoked by a long stretch of pseudo-random input valids, comma flags and consumer ready with alignment armed. A behavioural pair model in the bench, built on a queue, is compared with the outputs and `in_ready` after every clock edge.

// File: rtl/hrca_pkg.sv
package hrca_pkg;
  localparam int NSLOT = 2;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PASS,
    ACT_HOLD,
    ACT_SLIP,
    ACT_EMIT
  } act_e;

  function automatic logic align_armed(input logic half_rate,
                                       input logic frm_en,
                                       input logic frm_mode_off);
    return half_rate & frm_en & ~frm_mode_off;
  endfunction
endpackage

// File: rtl/hrca_phase.sv
module hrca_phase
  import hrca_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              half_rate,
  input  logic              armed,
  input  logic [CHAR_W-1:0] ch,
  input  logic              comma,
  output logic              emit,
  output logic [CHAR_W-1:0] e_char [NSLOT],
  output logic              e_comma [NSLOT]
);
  phase_e            ph_q;
  logic [CHAR_W-1:0] hold_char_q;
  logic              hold_comma_q;
  act_e              act;

  always_comb begin
    act = ACT_IDLE;
    if (take) begin
      if (!half_rate)           act = ACT_PASS;
      else if (ph_q == PH_EVEN) act = ACT_HOLD;
      else if (armed && comma)  act = ACT_SLIP;
      else                      act = ACT_EMIT;
    end
  end

  always_comb begin
    emit       = (act == ACT_PASS) || (act == ACT_EMIT);
    e_char[0]  = ch;
    e_comma[0] = comma;
    e_char[1]  = '0;
    e_comma[1] = 1'b0;
    if (act == ACT_EMIT) begin
      e_char[0]  = hold_char_q;
      e_comma[0] = hold_comma_q;
      e_char[1]  = ch;
      e_comma[1] = comma;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q         <= PH_EVEN;
      hold_char_q  <= '0;
      hold_comma_q <= 1'b0;
    end else if (!half_rate) begin
      ph_q         <= PH_EVEN;
      hold_comma_q <= 1'b0;
    end else begin
      case (act)
        ACT_HOLD, ACT_SLIP: begin
          ph_q         <= PH_ODD;
          hold_char_q  <= ch;
          hold_comma_q <= comma;
        end
        ACT_EMIT: ph_q <= PH_EVEN;
        default:  ph_q <= ph_q;
      endcase
    end
  end
endmodule

// File: rtl/hrca_outreg.sv
module hrca_outreg
  import hrca_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] d_char [NSLOT],
  input  logic              d_comma [NSLOT],
  input  logic              drain,
  output logic              valid,
  output logic [CHAR_W-1:0] q_char [NSLOT],
  output logic              q_comma [NSLOT]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (drain) valid <= 1'b0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_char[s]  <= '0;
        q_comma[s] <= 1'b0;
      end else if (load) begin
        q_char[s]  <= d_char[s];
        q_comma[s] <= d_comma[s];
      end
    end
  end
endmodule

// File: rtl/hrca_aligner.sv
module hrca_aligner
  import hrca_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_comma,
  input  logic              frm_en,
  input  logic              frm_mode_off,
  input  logic              half_rate,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] slot0_char,
  output logic              slot0_comma,
  output logic [CHAR_W-1:0] slot1_char,
  output logic              slot1_comma
);
  logic              take;
  logic              armed;
  logic              emit;
  logic [CHAR_W-1:0] e_char  [NSLOT];
  logic              e_comma [NSLOT];
  logic [CHAR_W-1:0] q_char  [NSLOT];
  logic              q_comma [NSLOT];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign armed    = align_armed(half_rate, frm_en, frm_mode_off);

  hrca_phase #(.CHAR_W(CHAR_W)) i_phase (
    .clk(clk), .rst_n(rst_n), .take(take), .half_rate(half_rate),
    .armed(armed), .ch(in_char), .comma(in_comma),
    .emit(emit), .e_char(e_char), .e_comma(e_comma)
  );

  hrca_outreg #(.CHAR_W(CHAR_W)) i_outreg (
    .clk(clk), .rst_n(rst_n), .load(emit), .d_char(e_char),
    .d_comma(e_comma), .drain(out_ready), .valid(out_valid),
    .q_char(q_char), .q_comma(q_comma)
  );

  assign slot0_char  = q_char[0];
  assign slot0_comma = q_comma[0];
  assign slot1_char  = q_char[1];
  assign slot1_comma = q_comma[1];
endmodule

// File: rtl/hrca_chk.sv
module hrca_chk #(
  parameter int CHAR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CHAR_W-1:0] in_char,
  input logic              in_comma,
  input logic              frm_en,
  input logic              frm_mode_off,
  input logic              half_rate,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] slot0_char,
  input logic              slot0_comma,
  input logic [CHAR_W-1:0] slot1_char,
  input logic              slot1_comma
);
  logic acc;
  logic arm;
  logic seen_q;
  assign acc = in_valid && in_ready;
  assign arm = half_rate && frm_en && !frm_mode_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seen_q <= 1'b0;
    else if (acc) seen_q <= 1'b1;
  end

  // R1
  p_no_pair_before_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_q);

  // R3 / R4: an armed comma never completes a pair
  p_comma_not_closing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && arm && in_comma) |=> !out_valid);

  // R6
  p_full_rate_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !half_rate) |=> (out_valid && slot0_char == $past(in_char)
                             && slot0_comma == $past(in_comma) && !slot1_comma));

  // R7
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(slot0_char) && $stable(slot1_char)
                                   && $stable(slot0_comma) && $stable(slot1_comma)));

  p_no_take_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  p_no_odd_comma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && arm) |=> !(out_valid && slot1_comma));
endmodule

bind hrca_aligner hrca_chk #(.CHAR_W(CHAR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_char(in_char), .in_comma(in_comma), .frm_en(frm_en),
  .frm_mode_off(frm_mode_off), .half_rate(half_rate), .out_valid(out_valid),
  .out_ready(out_ready), .slot0_char(slot0_char), .slot0_comma(slot0_comma),
  .slot1_char(slot1_char), .slot1_comma(slot1_comma)
);

// File: tb/test_hrca_aligner.sv
`timescale 1ns/1ps
module test_hrca_aligner;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_comma = 1'b0, frm_en = 1'b0, frm_mode_off = 1'b0;
  logic half_rate = 1'b1, out_ready = 1'b1;
  logic [W-1:0] in_char = '0;
  logic in_ready, out_valid, slot0_comma, slot1_comma;
  logic [W-1:0] slot0_char, slot1_char;

  always #10 clk = ~clk;

  hrca_aligner #(.CHAR_W(W)) i_hrca_aligner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .in_comma(in_comma), .frm_en(frm_en),
    .frm_mode_off(frm_mode_off), .half_rate(half_rate), .out_valid(out_valid),
    .out_ready(out_ready), .slot0_char(slot0_char), .slot0_comma(slot0_comma),
    .slot1_char(slot1_char), .slot1_comma(slot1_comma)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  logic [W-1:0] hq_c[$];
  logic         hq_k[$];
  logic         m_ov = 1'b0, m_k0 = 1'b0, m_k1 = 1'b0;
  logic [W-1:0] m_s0 = '0, m_s1 = '0;

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic acc, arm;
    cycles++;
    if (!rst_n) begin
      m_ov = 1'b0; hq_c.delete(); hq_k.delete();
    end else begin
      acc = in_valid && (!m_ov || out_ready);
      arm = half_rate && frm_en && !frm_mode_off;
      if (m_ov && out_ready) m_ov = 1'b0;
      if (!half_rate) begin
        hq_c.delete(); hq_k.delete();
        if (acc) begin
          m_ov = 1'b1; m_s0 = in_char; m_k0 = in_comma; m_s1 = '0; m_k1 = 1'b0;
        end
      end else if (acc) begin
        if (hq_c.size() == 0) begin
          hq_c.push_back(in_char); hq_k.push_back(in_comma);
        end else if (arm && in_comma) begin
          hq_c.delete(); hq_k.delete();
          hq_c.push_back(in_char); hq_k.push_back(in_comma);
        end else begin
          m_ov = 1'b1; m_s0 = hq_c[0]; m_k0 = hq_k[0]; m_s1 = in_char; m_k1 = in_comma;
          hq_c.delete(); hq_k.delete();
        end
      end
    end
    #5;
    chk("out_valid", out_valid, m_ov);
    chk("in_ready", in_ready, (!m_ov || out_ready));
    if (m_ov && out_valid) begin
      chk("slot0_char", slot0_char, m_s0);
      chk("slot0_comma", slot0_comma, m_k0);
      chk("slot1_char", slot1_char, m_s1);
      chk("slot1_comma", slot1_comma, m_k1);
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] c, input logic k, input logic r);
    @(negedge clk);
    in_valid = v; in_char = c; in_comma = k; out_ready = r;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state and no pair until two characters in half-rate
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    drive(1'b1, 10'h011, 1'b0, 1'b1);
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    drive(1'b1, 10'h022, 1'b0, 1'b1);
    // R2: free pairing, framing off
    cur_req = "R2";
    for (int i = 0; i < 8; i++) drive(1'b1, W'(10'h100 + i), 1'b0, 1'b1);
    // R4: armed, comma in even phase
    cur_req = "R4";
    frm_en = 1'b1;
    drive(1'b1, 10'h3BC, 1'b1, 1'b1);
    drive(1'b1, 10'h0A1, 1'b0, 1'b1);
    // R3: armed, comma in odd phase slips
    cur_req = "R3";
    drive(1'b1, 10'h0B2, 1'b0, 1'b1);
    drive(1'b1, 10'h3BC, 1'b1, 1'b1);
    drive(1'b1, 10'h0C3, 1'b0, 1'b1);
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    // R5: framing disabled lets comma land in slot 1
    cur_req = "R5";
    frm_en = 1'b0;
    drive(1'b1, 10'h0D4, 1'b0, 1'b1);
    drive(1'b1, 10'h3BC, 1'b1, 1'b1);
    frm_en = 1'b1; frm_mode_off = 1'b1;
    drive(1'b1, 10'h0E5, 1'b0, 1'b1);
    drive(1'b1, 10'h3BC, 1'b1, 1'b1);
    frm_mode_off = 1'b0;
    // R6: full-rate pass-through, comma ignored for alignment
    cur_req = "R6";
    half_rate = 1'b0;
    drive(1'b1, 10'h0F6, 1'b0, 1'b1);
    drive(1'b1, 10'h3BC, 1'b1, 1'b1);
    drive(1'b1, 10'h107, 1'b0, 1'b1);
    // R8: leaving half-rate mid-pair drops the held character
    cur_req = "R8";
    half_rate = 1'b1;
    drive(1'b1, 10'h118, 1'b0, 1'b1);
    half_rate = 1'b0;
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    half_rate = 1'b1;
    drive(1'b1, 10'h129, 1'b0, 1'b1);
    drive(1'b1, 10'h13A, 1'b0, 1'b1);
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    // R7: back-pressure hold
    cur_req = "R7";
    drive(1'b1, 10'h14B, 1'b0, 1'b0);
    drive(1'b1, 10'h15C, 1'b0, 1'b0);
    drive(1'b1, 10'h16D, 1'b0, 1'b0);
    drive(1'b1, 10'h16D, 1'b0, 1'b0);
    drive(1'b1, 10'h16D, 1'b0, 1'b1);
    // R9: random stress with alignment armed; slip may meet drain
    cur_req = "R9";
    for (int i = 0; i < 3000; i++)
      drive(($urandom_range(0, 3) != 0), W'($urandom_range(0, 1023)),
            ($urandom_range(0, 4) == 0), ($urandom_range(0, 2) != 0));
    // R7 again with all modes varying
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      frm_en = ($urandom_range(0, 3) != 0);
      frm_mode_off = ($urandom_range(0, 7) == 0);
      half_rate = ($urandom_range(0, 15) != 0);
      in_valid = ($urandom_range(0, 3) != 0);
      in_char = W'($urandom_range(0, 1023));
      in_comma = ($urandom_range(0, 3) == 0);
      out_ready = ($urandom_range(0, 1) != 0);
    end
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    drive(1'b0, 10'h000, 1'b0, 1'b1);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule